// File: doc/BRIEF.md
# Harris Corner Flag Generator for a Recency Surface

This block consumes a raster stream of 8-bit pseudo-intensity values taken from an event recency surface and evaluates a Harris corner response at every pixel. Horizontal and vertical gradients come from 3x3 Sobel kernels. Their products are summed over a 5x5 window to form the structure tensor. The response is compared against a programmable signed threshold, and the resulting one-bit verdict is written into a per-pixel flag table.

The flag table has two banks. While one frame's flags are being written, lookups read the last completed frame. An event's corner status is therefore a single registered read addressed by its coordinates, with no arithmetic done per event. The response weight k is given in 1/256 units; a value of 10 gives roughly 0.039.

Top module: `harris_flagger`

## Requirements
- R1: For an interior pixel the flag is 1 exactly when 256*(Sxx*Syy - Sxy^2) - k*(Sxx+Syy)^2 > 256*thresh. Here Gx is right column minus left column and Gy is bottom row minus top row, each with weights 1,2,1. The sums S run over the 5x5 window centred on the pixel, and k is k_frac.
- R2: A pixel with pix_sof high is pixel (0,0). A pixel with pix_eol high ends its row. Only cycles with pix_valid high advance the stream. A partial frame followed by a new pix_sof is discarded in favour of the restarted frame.
- R3: A pixel with x<3, x>W-4, y<3 or y>H-4 has flag 0.
- R4: A frame's flags become visible to lookups in the cycle after its last pixel (pix_eol on row H-1) is accepted. Until then, lookups return the previous completed frame, even while the next frame is half written.
- R5: lk_flag reflects the lk_x/lk_y presented one clock earlier. A coordinate outside the frame returns 0.
- R6: After reset, and before any frame completes, every lookup returns 0.
- R7: thresh is signed. With a negative threshold, a flat interior region (response 0) is flagged 1.
- R8: Full-contrast inputs (alternating 0 and 255) give exact results with no internal overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a row |
| pix_data | input | 8 | Surface value |
| k_frac | input | 8 | Response weight k in 1/256 units |
| thresh | input | THW | Signed response threshold |
| lk_x | input | clog2(W) | Lookup column |
| lk_y | input | clog2(H) | Lookup row |
| lk_flag | output | 1 | Corner flag of the looked-up pixel, one cycle later |

## Verification
A corrupted line buffer or window register cannot be seen directly. It changes the response of every interior pixel whose 5x5 support touches the bad column, so flags differ from the reference at the first full-table lookup after that frame completes. A wrong bank pointer shows at once during a mid-frame lookup: the table then returns half-written or stale content instead of the previous frame. A wrong row or column counter moves corners to other addresses or leaves flags set on the border ring, and both of these are visible on the next frame's lookups.

// File: rtl/hcs_pkg.sv
`timescale 1ns/1ps
package hcs_pkg;
    localparam int PIXW  = 8;
    localparam int GRADW = 11;
    localparam int PRODW = 22;
    localparam int ACCW  = 28;
    localparam int RESPW = 72;

    typedef logic signed [GRADW-1:0] grad_t;
    typedef logic signed [PRODW-1:0] prod_t;
    typedef logic signed [ACCW-1:0]  acc_t;

    typedef struct packed {
        prod_t xx;
        prod_t xy;
        prod_t yy;
    } ptrip_t;

    typedef struct packed {
        acc_t xx;
        acc_t xy;
        acc_t yy;
    } atrip_t;
endpackage

// File: rtl/hcs_sobel.sv
`timescale 1ns/1ps
module hcs_sobel
    import hcs_pkg::*;
(
    input  logic [2:0][2:0][PIXW-1:0] win,   // [column][row], column 2 newest, row 2 bottom
    output grad_t                     gx,
    output grad_t                     gy
);
    grad_t p [3][3];

    always_comb begin
        for (int c = 0; c < 3; c++) begin
            for (int r = 0; r < 3; r++) begin
                p[c][r] = grad_t'({3'b000, win[c][r]});
            end
        end
        gx = (p[2][0] + (p[2][1] <<< 1) + p[2][2]) - (p[0][0] + (p[0][1] <<< 1) + p[0][2]);
        gy = (p[0][2] + (p[1][2] <<< 1) + p[2][2]) - (p[0][0] + (p[1][0] <<< 1) + p[2][0]);
    end
endmodule

// File: rtl/hcs_response.sv
`timescale 1ns/1ps
module hcs_response
    import hcs_pkg::*;
#(
    parameter int THW = 48
) (
    input  atrip_t                 s,
    input  logic [7:0]             k,
    input  logic signed [THW-1:0]  thr,
    output logic                   hit
);
    localparam int RW = RESPW;
    logic signed [RW-1:0] xx, xy, yy, kk, det, tr, lhs, rhs;

    always_comb begin
        xx  = RW'(s.xx);
        xy  = RW'(s.xy);
        yy  = RW'(s.yy);
        kk  = RW'($signed({1'b0, k}));
        det = xx * yy - xy * xy;
        tr  = xx + yy;
        lhs = (det <<< 8) - kk * tr * tr;
        rhs = RW'(thr) <<< 8;
        hit = lhs > rhs;
    end
endmodule

// File: rtl/harris_flagger.sv
`timescale 1ns/1ps
module harris_flagger
    import hcs_pkg::*;
#(
    parameter int W   = 16,
    parameter int H   = 12,
    parameter int THW = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pix_valid,
    input  logic                    pix_sof,
    input  logic                    pix_eol,
    input  logic [PIXW-1:0]         pix_data,
    input  logic [7:0]              k_frac,
    input  logic signed [THW-1:0]   thresh,
    input  logic [$clog2(W)-1:0]    lk_x,
    input  logic [$clog2(H)-1:0]    lk_y,
    output logic                    lk_flag
);
    localparam int XW     = $clog2(W);
    localparam int YW     = $clog2(H);
    localparam int NPIX   = W * H;
    localparam int MARGIN = 3;           // Sobel reach 1 + window reach 2
    localparam int LAG    = 2 * MARGIN;  // input column at which a centre is complete
    localparam int PROWS  = 4;           // product rows held besides the current one

    typedef struct packed {
        logic [XW-1:0]                   x;
        logic [YW-1:0]                   y;
        logic [W-1:0][PIXW-1:0]          lb0;   // row y-1
        logic [W-1:0][PIXW-1:0]          lb1;   // row y-2
        logic [2:0][2:0][PIXW-1:0]       win;
        ptrip_t [PROWS-1:0][W-1:0]       plb;   // plb[0] newest product row
        atrip_t [PROWS-1:0]              csum;  // csum[PROWS-1] newest column sum
        logic [1:0][NPIX-1:0]            flags;
        logic                            wbank;
        logic                            seen;
        logic                            lk_flag;
    } st_t;

    st_t s_d, s_q;

    logic [XW-1:0]             cx_in;
    logic [YW-1:0]             cy_in;
    logic [2:0][2:0][PIXW-1:0] win_n;
    grad_t                     gx, gy;
    ptrip_t                    pnew;
    atrip_t                    colsum, total;
    logic                      hit;
    int                        ci, gc, waddr, caddr, raddr;

    assign cx_in = pix_sof ? '0 : s_q.x;
    assign cy_in = pix_sof ? '0 : s_q.y;

    always_comb begin
        ci       = (int'(cx_in) < W) ? int'(cx_in) : W - 1;
        win_n[0] = s_q.win[1];
        win_n[1] = s_q.win[2];
        win_n[2] = {pix_data, s_q.lb0[ci], s_q.lb1[ci]};
    end

    hcs_sobel u_sobel (
        .win (win_n),
        .gx  (gx),
        .gy  (gy)
    );

    always_comb begin
        gc      = (ci == 0) ? 0 : ci - 1;
        pnew.xx = prod_t'(gx) * prod_t'(gx);
        pnew.xy = prod_t'(gx) * prod_t'(gy);
        pnew.yy = prod_t'(gy) * prod_t'(gy);
        colsum.xx = acc_t'(pnew.xx);
        colsum.xy = acc_t'(pnew.xy);
        colsum.yy = acc_t'(pnew.yy);
        for (int r = 0; r < PROWS; r++) begin
            colsum.xx = colsum.xx + acc_t'(s_q.plb[r][gc].xx);
            colsum.xy = colsum.xy + acc_t'(s_q.plb[r][gc].xy);
            colsum.yy = colsum.yy + acc_t'(s_q.plb[r][gc].yy);
        end
        total = colsum;
        for (int c = 0; c < PROWS; c++) begin
            total.xx = total.xx + s_q.csum[c].xx;
            total.xy = total.xy + s_q.csum[c].xy;
            total.yy = total.yy + s_q.csum[c].yy;
        end
    end

    hcs_response #(.THW(THW)) u_resp (
        .s   (total),
        .k   (k_frac),
        .thr (thresh),
        .hit (hit)
    );

    always_comb begin
        s_d   = s_q;
        waddr = int'(cy_in) * W + ci;
        caddr = (int'(cy_in) - MARGIN) * W + (ci - MARGIN);
        raddr = int'(lk_y) * W + int'(lk_x);

        if (pix_valid) begin
            s_d.lb1[ci] = s_q.lb0[ci];
            s_d.lb0[ci] = pix_data;
            s_d.win     = win_n;
            for (int r = PROWS - 1; r > 0; r--) begin
                s_d.plb[r][gc] = s_q.plb[r-1][gc];
            end
            s_d.plb[0][gc] = pnew;
            for (int c = 0; c < PROWS - 1; c++) begin
                s_d.csum[c] = s_q.csum[c+1];
            end
            s_d.csum[PROWS-1] = colsum;

            if (waddr < NPIX) begin
                s_d.flags[s_q.wbank][waddr] = 1'b0;
            end
            if (ci >= LAG && int'(cy_in) >= LAG && caddr < NPIX) begin
                s_d.flags[s_q.wbank][caddr] = hit;
            end

            if (pix_eol) begin
                s_d.x = '0;
                if (int'(cy_in) == H - 1) begin
                    s_d.y     = '0;
                    s_d.wbank = ~s_q.wbank;
                    s_d.seen  = 1'b1;
                end else begin
                    s_d.y = cy_in + 1'b1;
                end
            end else begin
                s_d.x = cx_in + 1'b1;
                s_d.y = cy_in;
            end
        end

        if (int'(lk_x) < W && int'(lk_y) < H) begin
            s_d.lk_flag = s_q.flags[~s_q.wbank][raddr];
        end else begin
            s_d.lk_flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lk_flag = s_q.lk_flag;

    // R4: the last pixel of a frame flips the bank that lookups read
    a_r4_bank_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_eol && int'(cy_in) == H - 1) |=> (s_q.wbank != $past(s_q.wbank)));

    // R5: out-of-frame coordinates return no corner
    a_r5_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lk_y) >= H || int'(lk_x) >= W) |=> !lk_flag);

    // R3: the border ring never reads back as a corner
    a_r3_border_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lk_x) < MARGIN || int'(lk_y) < MARGIN ||
         int'(lk_x) > W - 1 - MARGIN || int'(lk_y) > H - 1 - MARGIN) |=> !lk_flag);

    // R6: nothing is flagged before the first completed frame
    a_r6_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.seen |=> !lk_flag);

    // R2: an accepted pixel that does not end its row advances the column
    a_r2_column_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_eol) |=> (s_q.x == $past(cx_in) + 1'b1));
endmodule

// File: tb/harris_flagger_test.sv
`timescale 1ns/1ps
module harris_flagger_test;
    localparam int W = 16;
    localparam int H = 12;
    localparam int THW = 48;

    logic clk = 0;
    logic rst_n = 0;
    logic pix_valid = 0, pix_sof = 0, pix_eol = 0;
    logic [7:0] pix_data = 0;
    logic [7:0] k_frac = 8'd10;
    logic signed [THW-1:0] thresh = '0;
    logic [3:0] lk_x = 0;
    logic [3:0] lk_y = 0;
    logic lk_flag;
    logic lk_req = 0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit    exp;
        string tag;
        int    x;
        int    y;
    } item_t;
    item_t sb[$];

    int img [H][W];
    bit cur_f [H][W];
    bit prev_f [H][W];

    always #2 clk = ~clk;

    harris_flagger #(.W(W), .H(H), .THW(THW)) uut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .pix_eol(pix_eol), .pix_data(pix_data), .k_frac(k_frac), .thresh(thresh),
        .lk_x(lk_x), .lk_y(lk_y), .lk_flag(lk_flag)
    );

    function automatic longint gxr(int a, int b);
        return (img[b-1][a+1] + 2*img[b][a+1] + img[b+1][a+1])
             - (img[b-1][a-1] + 2*img[b][a-1] + img[b+1][a-1]);
    endfunction

    function automatic longint gyr(int a, int b);
        return (img[b+1][a-1] + 2*img[b+1][a] + img[b+1][a+1])
             - (img[b-1][a-1] + 2*img[b-1][a] + img[b-1][a+1]);
    endfunction

    task automatic build_ref(int k, longint thr);
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                longint sxx = 0, sxy = 0, syy = 0, det, tr, lhs;
                cur_f[y][x] = 0;
                if (x >= 3 && x <= W-4 && y >= 3 && y <= H-4) begin
                    for (int v = -2; v <= 2; v++) begin
                        for (int u = -2; u <= 2; u++) begin
                            longint a = gxr(x+u, y+v);
                            longint b = gyr(x+u, y+v);
                            sxx += a*a; sxy += a*b; syy += b*b;
                        end
                    end
                    det = sxx*syy - sxy*sxy;
                    tr  = sxx + syy;
                    lhs = 256*det - longint'(k)*tr*tr;
                    cur_f[y][x] = (lhs > 256*thr);
                end
            end
        end
    endtask

    task automatic send_range(int from, int upto, bit gaps);
        for (int i = from; i <= upto; i++) begin
            int x = i % W;
            int y = i / W;
            @(negedge clk);
            pix_valid = 1; pix_sof = (i == 0); pix_eol = (x == W-1);
            pix_data = 8'(img[y][x]);
            if (gaps && (i % 5 == 0)) begin
                @(negedge clk);
                pix_valid = 0; pix_sof = 0; pix_eol = 0;
            end
        end
        @(negedge clk);
        pix_valid = 0; pix_sof = 0; pix_eol = 0;
    endtask

    task automatic look(int x, int y, bit exp, string tag);
        item_t it;
        @(negedge clk);
        lk_x = 4'(x); lk_y = 4'(y); lk_req = 1;
        it.exp = exp; it.tag = tag; it.x = x; it.y = y;
        sb.push_back(it);
    endtask

    task automatic look_done();
        @(negedge clk);
        lk_req = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_table(bit use_prev, string itag);
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                bit border = (x < 3 || x > W-4 || y < 3 || y > H-4);
                bit e = use_prev ? prev_f[y][x] : cur_f[y][x];
                look(x, y, e, border ? "R3" : itag);
            end
        end
        look_done();
    endtask

    // monitor: scoreboard compare one cycle after each lookup
    always @(posedge clk) begin
        #1;
        if (lk_req) begin
            item_t it;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R5 lookup result with empty scoreboard, actual %0b expected none", lk_flag);
            end else begin
                it = sb.pop_front();
                checks++;
                if (lk_flag !== it.exp) begin
                    errors++;
                    $display("FAIL %s at (%0d,%0d): actual %0b expected %0b",
                             it.tag, it.x, it.y, lk_flag, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R6: empty table after reset
        for (int i = 0; i < 8; i++) look(4 + i, 4, 1'b0, "R6");
        look_done();

        // Frame A: bright rectangle, R1
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                img[y][x] = (x >= 5 && x <= 10 && y >= 4 && y <= 7) ? 200 : 20;
        k_frac = 8'd10; thresh = '0;
        build_ref(10, 0);
        send_range(0, W*H-1, 1'b1);
        check_table(1'b0, "R1");
        prev_f = cur_f;

        // Frame B: full-contrast checkerboard, first half only (R4)
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                img[y][x] = (((x >> 1) ^ (y >> 1)) & 1) ? 255 : 0;
        k_frac = 8'd13; thresh = 48'sd1000000;
        build_ref(13, 1000000);
        send_range(0, (W*H)/2, 1'b0);
        check_table(1'b1, "R4");
        send_range((W*H)/2 + 1, W*H-1, 1'b0);
        check_table(1'b0, "R8");

        // R5: rows beyond the frame
        for (int y = H; y < 16; y++) look(5, y, 1'b0, "R5");
        look_done();

        // Frame C: flat image with negative threshold (R7)
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                img[y][x] = 100;
        k_frac = 8'd10; thresh = -48'sd1;
        build_ref(10, -1);
        send_range(0, W*H-1, 1'b0);
        check_table(1'b0, "R7");

        // Frame D: partial stray frame, then a restart by start-of-frame (R2)
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                img[y][x] = 255 - ((x * 37 + y * 91 + x * y * 13) % 256);
        k_frac = 8'd15; thresh = 48'sd50000;
        build_ref(15, 50000);
        send_range(0, 40, 1'b1);
        send_range(0, W*H-1, 1'b1);
        check_table(1'b0, "R2");

        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R5 scoreboard left %0d items, expected 0", sb.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule